// File: doc/BRIEF.md
# Downstream Command Frame Serializer

This block sits on the controller side of a narrow serial memory channel. Once per frame period, which is one memory command clock, it takes up to three memory commands from three independent slot inputs. It places them in a 120-bit frame with a short header, reserved zero padding and a CRC-16 check field. It then drives that frame out over a 10-lane double-data-rate link. The frame goes out as 12 transfers over 6 link clock cycles, so the frame rate stays locked to one sixth of the link clock.

The block runs entirely on the link clock. For each cycle it presents two 10-bit words: `lanes_rise` carries the transfer for the rising edge and `lanes_fall` carries the transfer for the falling edge. An output double-data-rate register multiplexes them onto the physical lanes. A frame is sent every period. When no command is pending, every slot carries the no-op encoding. The upstream scheduler sees one accept window per period, in which all three ready signals are high together. A slot whose valid is high in that window is taken. Valid values at any other time have no effect.

Top module: `cfs_frame_serializer`

## Requirements
- R1: While reset is low, and in the link cycles after release until the first frame starts, `frame_start`, `lanes_rise`, `lanes_fall` and `cmd_ready` are all zero. Reset is synchronous and active low.
- R2: All three `cmd_ready` bits are high together for exactly one link cycle in every six. The first such cycle is the fifth link cycle after the first rising edge that samples `rst_n` high.
- R3: A command in slot i is captured only at the rising edge that ends the ready cycle, and only if `cmd_valid[i]` is high there. A valid value or data value presented in any other cycle never appears in a frame.
- R4: `frame_start` is high for one link cycle, the cycle right after each ready cycle. Frames therefore start every 6 link cycles, and the first one starts after the sixth rising edge following reset release.
- R5: In cycle c (0..5) of a frame, counted from the `frame_start` cycle, `lanes_rise` carries transfer 2c and `lanes_fall` carries transfer 2c+1. Transfer k carries frame bits [10k+9:10k].
- R6: Frame bits [3:0] are the header. Bits [3:2] are the constant 2'b10 and bits [1:0] are the number of accepted commands. Slot i occupies bits [24i+27:24i+4]: its top bit is 1 for a carried command, and its low 23 bits are `cmd_data[23i+22:23i]`.
- R7: A slot with no accepted command is all zero (the no-op). A frame with all slots empty is still sent every period.
- R8: Frame bits [103:76] are always zero.
- R9: Frame bits [119:104] hold a CRC over bits [103:0]. It uses the generator polynomial 0x1021 and the initial value 0xFFFF, with no final inversion. Bit 0 is fed first into a left-shifting register, and register bit 15 lands on frame bit 119.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, six times the command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 3 | Per-slot command offered |
| cmd_data | input | 69 | Three 23-bit command words, slot i at [23i+22:23i] |
| cmd_ready | output | 3 | Per-slot accept window, high one cycle per frame |
| lanes_rise | output | 10 | Transfer for the rising half of this link cycle |
| lanes_fall | output | 10 | Transfer for the falling half of this link cycle |
| frame_start | output | 1 | High in the first link cycle of each frame |

## Verification
The assertions check the following on every cycle:
- the quiet outputs during reset;
- that the three ready bits always agree;
- the fixed six-cycle spacing of frame starts, and that each start follows an accept window;
- the header type code and the count of the commands handed over;
- the zero reserved field, checked in the lane cycles where it travels.

Only the bench scenarios can show the full frame contents. These are the slot payloads, the effect of valid levels held outside the window, and the CRC. For those checks the bench rebuilds each frame from the lanes and compares it to a frame predicted from the commands it offered.

// File: rtl/cfs_pkg.sv
// Shared constants for the downstream command frame serializer.
// Assumes: the default geometry is 10 lanes, 12 transfers, 3 slots and a 16-bit check.
package cfs_pkg;
    localparam int unsigned DEF_LANES  = 10;
    localparam int unsigned DEF_XFERS  = 12;
    localparam int unsigned DEF_SLOTS  = 3;
    localparam int unsigned DEF_CMD_W  = 23;
    localparam int unsigned DEF_HDR_W  = 4;
    localparam int unsigned DEF_CRC_W  = 16;
    localparam logic [DEF_HDR_W-1:0] DEF_HDR_BASE = 4'b1000;
    localparam logic [DEF_CRC_W-1:0] DEF_CRC_POLY = 16'h1021;
    localparam logic [DEF_CRC_W-1:0] DEF_CRC_INIT = 16'hFFFF;
endpackage

// File: rtl/cfs_phase_ctr.sv
// Frame phase counter: walks 0..PHASES-1 on the link clock and flags the last phase.
// Assumes: PHASES >= 2; reset is synchronous and active low.
module cfs_phase_ctr #(
    parameter int unsigned PHASES = 6,
    parameter int unsigned PH_W   = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    logic [PH_W-1:0] phase_q;

    // Detect the final link cycle of the frame period.
    assign last  = (phase_q == PH_W'(PHASES - 1));
    assign phase = phase_q;

    // Advance the phase, wrapping at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (last) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfs_crc.sv
// Bit-serial CRC unrolled over a whole data word in one combinational pass.
// Assumes: data bit 0 enters first; left-shifting register; no final inversion.
module cfs_crc #(
    parameter int unsigned          DATA_W = 104,
    parameter int unsigned          CRC_W  = 16,
    parameter logic [CRC_W-1:0]     POLY   = 16'h1021,
    parameter logic [CRC_W-1:0]     INIT   = 16'hFFFF
) (
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] acc;
    logic             fb;

    // Fold every data bit into the check register in transmission order.
    always_comb begin
        acc = INIT;
        fb  = 1'b0;
        for (int i = 0; i < int'(DATA_W); i++) begin
            fb  = acc[CRC_W-1] ^ data[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc = acc;
    end
endmodule

// File: rtl/cfs_frame_pack.sv
// Frame packer: builds header, command slots, reserved padding and check field.
// Assumes: FRAME_W leaves a positive reserved field; slot count fits the header.
module cfs_frame_pack #(
    parameter int unsigned          SLOTS    = 3,
    parameter int unsigned          CMD_W    = 23,
    parameter int unsigned          HDR_W    = 4,
    parameter int unsigned          CRC_W    = 16,
    parameter int unsigned          FRAME_W  = 120,
    parameter logic [HDR_W-1:0]     HDR_BASE = 4'b1000,
    parameter logic [CRC_W-1:0]     CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0]     CRC_INIT = 16'hFFFF
) (
    input  logic [SLOTS-1:0]       cmd_valid,
    input  logic [SLOTS*CMD_W-1:0] cmd_data,
    input  logic                   accept,
    output logic [FRAME_W-1:0]     frame
);
    localparam int unsigned SLOT_W = CMD_W + 1;
    localparam int unsigned BODY_W = FRAME_W - CRC_W;
    localparam int unsigned RSV_W  = BODY_W - HDR_W - SLOTS * SLOT_W;
    localparam int unsigned CNT_W  = $clog2(SLOTS + 1);

    logic [SLOTS-1:0]        take;
    logic [SLOTS*SLOT_W-1:0] slot_bits;
    logic [CNT_W-1:0]        cnt;
    logic [HDR_W-1:0]        hdr;
    logic [BODY_W-1:0]       body;
    logic [CRC_W-1:0]        check;

    // Decide which slots are handed over in this window.
    assign take = cmd_valid & {SLOTS{accept}};

    // Form each slot: marker bit over payload, or all zero as the no-op.
    for (genvar g = 0; g < int'(SLOTS); g++) begin : g_slot
        assign slot_bits[g*SLOT_W +: SLOT_W] =
            take[g] ? {1'b1, cmd_data[g*CMD_W +: CMD_W]} : '0;
    end

    // Count the commands carried by this frame.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < int'(SLOTS); i++) begin
            cnt = cnt + CNT_W'(take[i]);
        end
    end

    // Merge the type code with the command count.
    assign hdr  = HDR_BASE | HDR_W'(cnt);
    assign body = {{RSV_W{1'b0}}, slot_bits, hdr};

    cfs_crc #(
        .DATA_W (BODY_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY),
        .INIT   (CRC_INIT)
    ) u_crc (
        .data (body),
        .crc  (check)
    );

    // Place the check field above the protected body.
    assign frame = {check, body};
endmodule

// File: rtl/cfs_lane_shift.sv
// Lane shifter: holds a frame and emits two lane words per link cycle.
// Assumes: load coincides with the last phase; phase runs 0..XFERS/2-1.
module cfs_lane_shift #(
    parameter int unsigned LANES   = 10,
    parameter int unsigned XFERS   = 12,
    parameter int unsigned FRAME_W = LANES * XFERS,
    parameter int unsigned PH_W    = $clog2(XFERS / 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PH_W-1:0]    phase,
    input  logic [FRAME_W-1:0] frame_in,
    output logic [LANES-1:0]   rise,
    output logic [LANES-1:0]   fall,
    output logic               start
);
    localparam int unsigned PHASES = XFERS / 2;
    localparam int unsigned STEP   = 2 * LANES;

    logic [FRAME_W-1:0] frame_q;
    logic [LANES-1:0]   rise_q;
    logic [LANES-1:0]   fall_q;
    logic               start_q;
    int unsigned        nxt_base;

    // Locate the lane pair for the following link cycle.
    always_comb begin
        if (int'(phase) >= int'(PHASES) - 1) begin
            nxt_base = 0;
        end else begin
            nxt_base = (int'(phase) + 1) * STEP;
        end
    end

    // Load a new frame at the boundary, otherwise step through the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            start_q <= 1'b0;
        end else if (load) begin
            frame_q <= frame_in;
            rise_q  <= frame_in[0 +: LANES];
            fall_q  <= frame_in[LANES +: LANES];
            start_q <= 1'b1;
        end else begin
            rise_q  <= frame_q[nxt_base +: LANES];
            fall_q  <= frame_q[nxt_base + LANES +: LANES];
            start_q <= 1'b0;
        end
    end

    assign rise  = rise_q;
    assign fall  = fall_q;
    assign start = start_q;
endmodule

// File: rtl/cfs_frame_serializer.sv
// Top: downstream command frame serializer for a 10-lane double-data-rate link.
// Assumes: clk is the link clock at six times the command clock; an external
// output register drives rise then fall words onto the lanes within each cycle.
module cfs_frame_serializer
    import cfs_pkg::*;
#(
    parameter int unsigned          LANES    = DEF_LANES,
    parameter int unsigned          XFERS    = DEF_XFERS,
    parameter int unsigned          SLOTS    = DEF_SLOTS,
    parameter int unsigned          CMD_W    = DEF_CMD_W,
    parameter int unsigned          HDR_W    = DEF_HDR_W,
    parameter int unsigned          CRC_W    = DEF_CRC_W,
    parameter logic [HDR_W-1:0]     HDR_BASE = DEF_HDR_BASE,
    parameter logic [CRC_W-1:0]     CRC_POLY = DEF_CRC_POLY,
    parameter logic [CRC_W-1:0]     CRC_INIT = DEF_CRC_INIT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOTS-1:0]       cmd_valid,
    input  logic [SLOTS*CMD_W-1:0] cmd_data,
    output logic [SLOTS-1:0]       cmd_ready,
    output logic [LANES-1:0]       lanes_rise,
    output logic [LANES-1:0]       lanes_fall,
    output logic                   frame_start
);
    localparam int unsigned FRAME_W = LANES * XFERS;
    localparam int unsigned PHASES  = XFERS / 2;
    localparam int unsigned PH_W    = $clog2(PHASES);

    logic [PH_W-1:0]    phase;
    logic               last;
    logic [FRAME_W-1:0] frame;

    cfs_phase_ctr #(
        .PHASES (PHASES),
        .PH_W   (PH_W)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .last  (last)
    );

    // Open the accept window for every slot in the final phase.
    assign cmd_ready = {SLOTS{last}};

    cfs_frame_pack #(
        .SLOTS    (SLOTS),
        .CMD_W    (CMD_W),
        .HDR_W    (HDR_W),
        .CRC_W    (CRC_W),
        .FRAME_W  (FRAME_W),
        .HDR_BASE (HDR_BASE),
        .CRC_POLY (CRC_POLY),
        .CRC_INIT (CRC_INIT)
    ) u_pack (
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .accept    (last),
        .frame     (frame)
    );

    cfs_lane_shift #(
        .LANES   (LANES),
        .XFERS   (XFERS),
        .FRAME_W (FRAME_W),
        .PH_W    (PH_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (last),
        .phase    (phase),
        .frame_in (frame),
        .rise     (lanes_rise),
        .fall     (lanes_fall),
        .start    (frame_start)
    );
endmodule

// File: rtl/cfs_checker.sv
// Property checker for the serializer, attached to every instance by bind.
// Assumes: default geometry (10 lanes, 3 slots, 6 link cycles per frame).
module cfs_checker #(
    parameter int unsigned LANES = 10,
    parameter int unsigned SLOTS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SLOTS-1:0] cmd_valid,
    input logic [SLOTS-1:0] cmd_ready,
    input logic [LANES-1:0] lanes_rise,
    input logic [LANES-1:0] lanes_fall,
    input logic             frame_start
);
    logic [2:0] pos_q;
    logic       seen_q;

    // Track link cycles elapsed since the latest frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            seen_q <= 1'b0;
        end else if (frame_start) begin
            pos_q  <= 3'd1;
            seen_q <= 1'b1;
        end else if (pos_q != 3'd7) begin
            pos_q  <= pos_q + 3'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!frame_start && lanes_rise == '0 && lanes_fall == '0));

    p_ready_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready == '0 || cmd_ready == '1));

    p_ready_then_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready[0] |=> frame_start);

    p_start_after_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(cmd_ready[0]));

    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    p_start_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && seen_q) |-> (pos_q == 3'd6));

    p_header_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (lanes_rise[3:2] == 2'b10 &&
                         32'(lanes_rise[1:0]) == $past($countones(cmd_valid & cmd_ready))));

    p_reserved_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !frame_start && pos_q == 3'd4) |-> (lanes_rise == '0 && lanes_fall == '0));

    p_reserved_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !frame_start && pos_q == 3'd3) |-> (lanes_fall[9:6] == 4'd0));
endmodule

bind cfs_frame_serializer cfs_checker #(.LANES(LANES), .SLOTS(SLOTS)) u_cfs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .lanes_rise  (lanes_rise),
    .lanes_fall  (lanes_fall),
    .frame_start (frame_start)
);

// File: tb/tb_cfs_frame_serializer.sv
module tb_cfs_frame_serializer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   cmd_valid = '0;
    logic [68:0]  cmd_data = '0;
    logic [2:0]   cmd_ready;
    logic [9:0]   lanes_rise;
    logic [9:0]   lanes_fall;
    logic         frame_start;

    int           n_chk = 0;
    int           n_fail = 0;
    int           cyc = 0;
    int           rel_cyc = 0;
    int           last_fs = -1;
    int           frames_seen = 0;
    bit           done = 1'b0;
    logic [119:0] exp_q[$];

    cfs_frame_serializer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_data    (cmd_data),
        .cmd_ready   (cmd_ready),
        .lanes_rise  (lanes_rise),
        .lanes_fall  (lanes_fall),
        .frame_start (frame_start)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] ref_crc(input logic [103:0] b);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < 104; i++) begin
            logic f = c[15] ^ b[i];
            c = {c[14:0], 1'b0};
            if (f) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [119:0] ref_frame(input logic [2:0] m, input logic [68:0] d);
        logic [103:0] b = '0;
        int n = 0;
        for (int s = 0; s < 3; s++) begin
            if (m[s]) begin
                b[4 + 24*s +: 24] = {1'b1, d[23*s +: 23]};
                n++;
            end
        end
        b[3:0] = {2'b10, 2'(n)};
        return {ref_crc(b), b};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [119:0] act, input logic [119:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: waits for the accept window, offers commands, records the expected frame.
    task automatic send(input logic [2:0] m, input logic [68:0] d, input bit noise);
        while (cmd_ready != 3'b111) @(negedge clk);
        cmd_valid = m;
        cmd_data  = d;
        exp_q.push_back(ref_frame(m, d));
        @(negedge clk);
        if (noise) begin
            cmd_valid = 3'b111;
            cmd_data  = '1;
        end else begin
            cmd_valid = '0;
            cmd_data  = '0;
        end
    endtask

    // Monitor: rebuilds each frame from the lanes and compares against the queue.
    initial begin
        logic [119:0] got;
        logic [119:0] exp;
        forever begin
            @(negedge clk);
            if (rst_n && frame_start) begin
                if (last_fs < 0)
                    chk(cyc - rel_cyc == 6, "R4 first start", 120'(cyc - rel_cyc), 120'd6);
                else
                    chk(cyc - last_fs == 6, "R4 start spacing", 120'(cyc - last_fs), 120'd6);
                last_fs = cyc;
                got = '0;
                for (int c = 0; c < 6; c++) begin
                    if (c > 0) begin
                        @(negedge clk);
                        chk(!frame_start, "R4 strobe width", 120'(frame_start), 120'd0);
                    end
                    got[20*c +: 10]      = lanes_rise;
                    got[20*c + 10 +: 10] = lanes_fall;
                end
                exp = (exp_q.size() > 0) ? exp_q.pop_front() : ref_frame(3'b000, '0);
                chk(got[3:0] == exp[3:0], "R6 header", 120'(got[3:0]), 120'(exp[3:0]));
                chk(got[75:4] == exp[75:4], "R6 R7 R3 slots", 120'(got[75:4]), 120'(exp[75:4]));
                chk(got[103:76] == '0, "R8 reserved", 120'(got[103:76]), 120'd0);
                chk(got[119:104] == ref_crc(got[103:0]), "R9 check field",
                    120'(got[119:104]), 120'(ref_crc(got[103:0])));
                chk(got == exp, "R5 lane order full frame", got, exp);
                frames_seen++;
            end
        end
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed = 32'h1234_5677;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!frame_start && lanes_rise == '0 && lanes_fall == '0 && cmd_ready == '0,
            "R1 in reset", {frame_start, lanes_rise, lanes_fall, cmd_ready}, 120'd0);
        rst_n   = 1'b1;
        rel_cyc = cyc;
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            chk(!frame_start && lanes_rise == '0 && lanes_fall == '0 && cmd_ready == '0,
                "R1 R2 before window", {frame_start, lanes_rise, lanes_fall, cmd_ready}, 120'd0);
        end
        @(negedge clk);
        chk(cmd_ready == 3'b111, "R2 first window", 120'(cmd_ready), 120'h7);

        send(3'b000, '0, 1'b0);                                          // R7 idle frame
        send(3'b111, {23'h2A_AAAA, 23'h15_5555, 23'h00_0001}, 1'b0);     // R6 all slots
        send(3'b010, {23'h0, 23'h7F_FFFF, 23'h0}, 1'b1);                 // single slot, then noise
        send(3'b000, '0, 1'b1);                                          // R3 noise not taken
        send(3'b101, {23'h1F_0F0F, 23'h3C_3C3C, 23'h55_AA55}, 1'b1);     // R3 slot 1 dropped
        send(3'b111, '1, 1'b0);                                          // all-ones payload
        for (int i = 0; i < 10; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            send(seed[2:0], {seed, seed ^ 32'hA5A5_5A5A, seed[4:0]}, seed[7]);
        end
        send(3'b000, '0, 1'b0);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (14) @(negedge clk);
        chk(frames_seen >= 18, "R7 frame every period", 120'(frames_seen), 120'd18);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule